// File: doc/BRIEF.md
# Three-Group Interrupt Controller

This block gathers peripheral event lines into three interrupt groups and drives two processor interrupt outputs: a normal interrupt line fed by the first two groups, and a fast interrupt line fed by the third. Each group has a status register, a mask register and a masked-request view. Software reaches all of them over a small synchronous register bus with byte-wide data and word offsets.

Group A latches its events. A rising edge on an input sets its status bit, and the bit stays set until software clears it by writing ones to the clear offset. Two bits of group A are special. Bit 7 always reads as one. Bit 4 is set by reset, so software can see that a power-on has happened.

Group B and the fast group do not latch. Their status registers copy the level inputs, one clock cycle late. The fast group implements only bits 0, 1, 2, 6 and 7; bits 3 to 5 always read as zero. Bits 0 and 1 of the fast group are meant for a disc controller's data-request and interrupt lines, and they rise and fall with those lines.

Top module: `ic3_intc`

## Requirements
- R1: Reset sets group A status to 0x90 (bit 4 power-on and bit 7 constant-one). Reset clears all three mask registers to 0x00, and `irq_o` and `fiq_o` are low after reset.
- R2: A 0-to-1 change on `evt_a_i[n]` sampled at a clock edge sets group A status bit n from that edge on. A level that stays high does not set the bit again after it has been cleared.
- R3: A write to offset 5 clears every group A status bit whose data bit is 1 and leaves the other bits unchanged. Bit 7 of group A status always reads 1.
- R4: When a clear of a group A bit and a rising edge on the same bit fall at the same clock edge, the bit stays set.
- R5: Each request offset returns its group's status ANDed with its group's mask: offset 5 for group A, offset 9 for group B, offset 13 for the fast group.
- R6: The masks are read/write at offset 6 (group A), offset 10 (group B) and offset 14 (fast group). The fast group mask keeps only bits 0, 1, 2, 6 and 7; its other bits read 0.
- R7: The group B status register (offset 8) equals `lvl_b_i` as sampled at the previous clock edge.
- R8: The fast group status register (offset 12) equals `lvl_f_i` ANDed with 0xC7, as sampled at the previous clock edge.
- R9: `irq_o` is high exactly when group A or group B has a nonzero masked request. `fiq_o` is high exactly when the fast group has a nonzero masked request.
- R10: Writes to offsets 4, 8, 9, 12 and 13, and to any offset without a register, change no state.
- R11: Reads of offsets without a register return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Bus access strobe for this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read, valid with `bus_sel_i` |
| bus_addr_i | input | 5 | Word offset of the register |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i`, combinational |
| evt_a_i | input | 8 | Group A event inputs, edge sensitive |
| lvl_b_i | input | 8 | Group B level inputs |
| lvl_f_i | input | 8 | Fast group level inputs |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with its default parameters. These are an 8-bit data width, a 5-bit offset, a reset value of 0x90 for group A, bit 7 as the sticky-one bit, and 0xC7 as the set of implemented fast-group bits. With these values the bench reaches the sticky-one bit, the power-on bit and the unimplemented fast-group bits through the ordinary offsets. It can therefore check the always-one bit against write-one-to-clear, and the forced-zero bits against both the level inputs and mask writes. The bench also exercises a clear and a rising edge on the same bit at the same edge, and a reset applied in the middle of the run.

// File: rtl/ic3_pkg.sv
package ic3_pkg;
  localparam int unsigned OFS_W = 5;

  localparam logic [OFS_W-1:0] OFS_STAT_A = 5'd4;
  localparam logic [OFS_W-1:0] OFS_REQ_A  = 5'd5;
  localparam logic [OFS_W-1:0] OFS_MASK_A = 5'd6;
  localparam logic [OFS_W-1:0] OFS_STAT_B = 5'd8;
  localparam logic [OFS_W-1:0] OFS_REQ_B  = 5'd9;
  localparam logic [OFS_W-1:0] OFS_MASK_B = 5'd10;
  localparam logic [OFS_W-1:0] OFS_STAT_F = 5'd12;
  localparam logic [OFS_W-1:0] OFS_REQ_F  = 5'd13;
  localparam logic [OFS_W-1:0] OFS_MASK_F = 5'd14;

  typedef enum logic [1:0] {
    GRP_A = 2'd0,
    GRP_B = 2'd1,
    GRP_F = 2'd2
  } grp_e;

  localparam int unsigned N_GRP = 3;
endpackage

// File: rtl/ic3_latch_grp.sv
module ic3_latch_grp #(
  parameter int unsigned   W       = 8,
  parameter logic [W-1:0]  RST_VAL = 8'h90,
  parameter logic [W-1:0]  STICKY  = 8'h80
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_bits_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] evt_q;
  logic [W-1:0] rise;
  logic [W-1:0] clr_eff;
  logic [W-1:0] stat_q;
  logic [W-1:0] stat_d;

  assign rise    = evt_i & ~evt_q;
  assign clr_eff = clr_en_i ? (clr_bits_i & ~STICKY) : '0;

  // set beats clear on the same bit
  always_comb begin
    stat_d = (stat_q & ~clr_eff) | rise | STICKY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      stat_q <= RST_VAL | STICKY;
    end else begin
      evt_q  <= evt_i;
      stat_q <= stat_d;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/ic3_level_grp.sv
module ic3_level_grp #(
  parameter int unsigned  W    = 8,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= lvl_i & IMPL;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/ic3_mask_reg.sv
module ic3_mask_reg #(
  parameter int unsigned  W    = 8,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_en_i) mask_q <= wdata_i & IMPL;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/ic3_intc.sv
module ic3_intc
  import ic3_pkg::*;
#(
  parameter int unsigned   DW       = 8,
  parameter int unsigned   AW       = OFS_W,
  parameter logic [DW-1:0] A_RESET  = 8'h90,
  parameter logic [DW-1:0] A_STICKY = 8'h80,
  parameter logic [DW-1:0] F_IMPL   = 8'hC7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel_i,
  input  logic          bus_wr_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic [DW-1:0] evt_a_i,
  input  logic [DW-1:0] lvl_b_i,
  input  logic [DW-1:0] lvl_f_i,
  output logic          irq_o,
  output logic          fiq_o
);
  localparam logic [DW-1:0] ALL_ONES = '1;

  logic          wr_stb;
  logic [DW-1:0] stat_a, stat_b, stat_f;
  logic [DW-1:0] mask_a, mask_b, mask_f;
  logic [DW-1:0] req_a, req_b, req_f;

  logic [DW-1:0]       grp_mask [N_GRP];
  logic [N_GRP-1:0]    mask_wr;

  assign wr_stb = bus_sel_i & bus_wr_i;

  ic3_latch_grp #(.W(DW), .RST_VAL(A_RESET), .STICKY(A_STICKY)) u_grp_a (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_a_i),
    .clr_en_i   (wr_stb && (bus_addr_i == AW'(OFS_REQ_A))),
    .clr_bits_i (bus_wdata_i),
    .stat_o     (stat_a)
  );

  ic3_level_grp #(.W(DW), .IMPL(ALL_ONES)) u_grp_b (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (lvl_b_i),
    .stat_o (stat_b)
  );

  ic3_level_grp #(.W(DW), .IMPL(F_IMPL)) u_grp_f (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (lvl_f_i),
    .stat_o (stat_f)
  );

  assign mask_wr[GRP_A] = wr_stb && (bus_addr_i == AW'(OFS_MASK_A));
  assign mask_wr[GRP_B] = wr_stb && (bus_addr_i == AW'(OFS_MASK_B));
  assign mask_wr[GRP_F] = wr_stb && (bus_addr_i == AW'(OFS_MASK_F));

  for (genvar g = 0; g < N_GRP; g++) begin : g_mask
    localparam logic [DW-1:0] IMPL_G = (g == GRP_F) ? F_IMPL : ALL_ONES;
    ic3_mask_reg #(.W(DW), .IMPL(IMPL_G)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en_i (mask_wr[g]),
      .wdata_i (bus_wdata_i),
      .mask_o  (grp_mask[g])
    );
  end

  assign mask_a = grp_mask[GRP_A];
  assign mask_b = grp_mask[GRP_B];
  assign mask_f = grp_mask[GRP_F];

  assign req_a = stat_a & mask_a;
  assign req_b = stat_b & mask_b;
  assign req_f = stat_f & mask_f;

  assign irq_o = (|req_a) | (|req_b);
  assign fiq_o = |req_f;

  always_comb begin
    unique case (bus_addr_i)
      AW'(OFS_STAT_A): bus_rdata_o = stat_a;
      AW'(OFS_REQ_A):  bus_rdata_o = req_a;
      AW'(OFS_MASK_A): bus_rdata_o = mask_a;
      AW'(OFS_STAT_B): bus_rdata_o = stat_b;
      AW'(OFS_REQ_B):  bus_rdata_o = req_b;
      AW'(OFS_MASK_B): bus_rdata_o = mask_b;
      AW'(OFS_STAT_F): bus_rdata_o = stat_f;
      AW'(OFS_REQ_F):  bus_rdata_o = req_f;
      AW'(OFS_MASK_F): bus_rdata_o = mask_f;
      default:         bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ic3_intc_chk.sv
module ic3_intc_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel_i,
  input logic          bus_wr_i,
  input logic [AW-1:0] bus_addr_i,
  input logic [DW-1:0] bus_wdata_i,
  input logic [DW-1:0] evt_a_i,
  input logic [DW-1:0] lvl_b_i,
  input logic [DW-1:0] stat_a,
  input logic [DW-1:0] stat_b,
  input logic [DW-1:0] mask_a
);
  logic [DW-1:0] evt_seen_q;
  logic          up_q;
  logic [DW-1:0] rise_c;
  logic          clr_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_seen_q <= '0;
      up_q       <= 1'b0;
    end else begin
      evt_seen_q <= evt_a_i;
      up_q       <= 1'b1;
    end
  end

  assign rise_c = evt_a_i & ~evt_seen_q;
  assign clr_c  = bus_sel_i && bus_wr_i && (bus_addr_i == AW'(5));

  // R2
  a_rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_c) |=> ((stat_a & $past(rise_c)) == $past(rise_c)));

  // R3
  a_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_c && ((rise_c & bus_wdata_i) == '0)) |=>
      ((stat_a & $past(bus_wdata_i) & 8'h7F) == '0));

  // R3
  a_sticky_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_a[7]);

  // R7
  b_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_q |-> (stat_b == $past(lvl_b_i)));

  // R6
  mask_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel_i && bus_wr_i && (bus_addr_i == AW'(6))) |=> $stable(mask_a));
endmodule

bind ic3_intc ic3_intc_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_sel_i   (bus_sel_i),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .evt_a_i     (evt_a_i),
  .lvl_b_i     (lvl_b_i),
  .stat_a      (stat_a),
  .stat_b      (stat_b),
  .mask_a      (mask_a)
);

// File: tb/ic3_intc_bench.sv
`timescale 1ns/1ps
module ic3_intc_bench;
  typedef struct packed {
    logic [3:0] req;
    logic       wr;
    logic [4:0] addr;
    logic [7:0] wd;
    logic [7:0] ev;
    logic [7:0] lb;
    logic [7:0] lf;
    logic [7:0] exp;
    logic       irq;
    logic       fiq;
  } vec_t;

  localparam int NV = 30;
  // req, wr, addr, wdata, evt_a, lvl_b, lvl_f, expected read, irq, fiq
  localparam vec_t VEC [NV] = '{
    '{4'd1,  1'b0, 5'd4,  8'h00, 8'h00, 8'h00, 8'h00, 8'h90, 1'b0, 1'b0}, // R1
    '{4'd1,  1'b0, 5'd6,  8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0}, // R1
    '{4'd6,  1'b1, 5'd6,  8'h81, 8'h00, 8'h00, 8'h00, 8'h81, 1'b1, 1'b0}, // R6
    '{4'd5,  1'b0, 5'd5,  8'h00, 8'h00, 8'h00, 8'h00, 8'h80, 1'b1, 1'b0}, // R5
    '{4'd3,  1'b1, 5'd5,  8'hFF, 8'h00, 8'h00, 8'h00, 8'h80, 1'b1, 1'b0}, // R3
    '{4'd6,  1'b1, 5'd6,  8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0}, // R6
    '{4'd3,  1'b0, 5'd4,  8'h00, 8'h00, 8'h00, 8'h00, 8'h80, 1'b0, 1'b0}, // R3
    '{4'd2,  1'b0, 5'd4,  8'h00, 8'h21, 8'h00, 8'h00, 8'hA1, 1'b0, 1'b0}, // R2
    '{4'd9,  1'b1, 5'd6,  8'h20, 8'h21, 8'h00, 8'h00, 8'h20, 1'b1, 1'b0}, // R9
    '{4'd3,  1'b1, 5'd5,  8'h20, 8'h21, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0}, // R3
    '{4'd2,  1'b0, 5'd4,  8'h00, 8'h21, 8'h00, 8'h00, 8'h81, 1'b0, 1'b0}, // R2
    '{4'd2,  1'b0, 5'd4,  8'h00, 8'h00, 8'h00, 8'h00, 8'h81, 1'b0, 1'b0}, // R2
    '{4'd4,  1'b1, 5'd5,  8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0}, // R4
    '{4'd4,  1'b0, 5'd4,  8'h00, 8'h01, 8'h00, 8'h00, 8'h81, 1'b0, 1'b0}, // R4
    '{4'd7,  1'b0, 5'd8,  8'h00, 8'h01, 8'h42, 8'h00, 8'h42, 1'b0, 1'b0}, // R7
    '{4'd6,  1'b1, 5'd10, 8'h40, 8'h01, 8'h42, 8'h00, 8'h40, 1'b1, 1'b0}, // R6
    '{4'd5,  1'b0, 5'd9,  8'h00, 8'h01, 8'h42, 8'h00, 8'h40, 1'b1, 1'b0}, // R5
    '{4'd7,  1'b0, 5'd8,  8'h00, 8'h01, 8'h02, 8'h00, 8'h02, 1'b0, 1'b0}, // R7
    '{4'd10, 1'b1, 5'd8,  8'hFF, 8'h01, 8'h02, 8'h00, 8'h02, 1'b0, 1'b0}, // R10
    '{4'd10, 1'b1, 5'd4,  8'h00, 8'h01, 8'h02, 8'h00, 8'h81, 1'b0, 1'b0}, // R10
    '{4'd8,  1'b0, 5'd12, 8'h00, 8'h01, 8'h02, 8'hFF, 8'hC7, 1'b0, 1'b0}, // R8
    '{4'd6,  1'b1, 5'd14, 8'hFF, 8'h01, 8'h02, 8'hFF, 8'hC7, 1'b0, 1'b1}, // R6
    '{4'd5,  1'b0, 5'd13, 8'h00, 8'h01, 8'h02, 8'hFF, 8'hC7, 1'b0, 1'b1}, // R5
    '{4'd8,  1'b0, 5'd13, 8'h00, 8'h01, 8'h02, 8'h02, 8'h02, 1'b0, 1'b1}, // R8
    '{4'd9,  1'b0, 5'd12, 8'h00, 8'h01, 8'h02, 8'h38, 8'h00, 1'b0, 1'b0}, // R9
    '{4'd11, 1'b0, 5'd0,  8'h00, 8'h01, 8'h02, 8'h38, 8'h00, 1'b0, 1'b0}, // R11
    '{4'd10, 1'b1, 5'd31, 8'hFF, 8'h01, 8'h02, 8'h38, 8'h00, 1'b0, 1'b0}, // R10
    '{4'd10, 1'b1, 5'd9,  8'hFF, 8'h01, 8'h02, 8'h38, 8'h00, 1'b0, 1'b0}, // R10
    '{4'd10, 1'b1, 5'd13, 8'hFF, 8'h01, 8'h02, 8'h38, 8'h00, 1'b0, 1'b0}, // R10
    '{4'd9,  1'b1, 5'd6,  8'h80, 8'h01, 8'h02, 8'h38, 8'h80, 1'b1, 1'b0}  // R9
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0;
  logic       wr = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] evt_a = '0;
  logic [7:0] lvl_b = '0;
  logic [7:0] lvl_f = '0;
  logic       irq, fiq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ic3_intc u_ic3_intc (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel_i   (sel),
    .bus_wr_i    (wr),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .evt_a_i     (evt_a),
    .lvl_b_i     (lvl_b),
    .lvl_f_i     (lvl_f),
    .irq_o       (irq),
    .fiq_o       (fiq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // drive one access at the current falling edge, then look one cycle later
  task automatic step(input logic w, input logic [4:0] a, input logic [7:0] d,
                      input logic [7:0] ea, input logic [7:0] lb, input logic [7:0] lf);
    sel = w; wr = w; addr = a; wdata = d;
    evt_a = ea; lvl_b = lb; lvl_f = lf;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
    #0.5;
  endtask

  task automatic rd(input logic [4:0] a);
    addr = a;
    #0.5;
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq after reset", {7'd0, irq}, 8'h00);
    check("R1 fiq after reset", {7'd0, fiq}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].wr, VEC[i].addr, VEC[i].wd, VEC[i].ev, VEC[i].lb, VEC[i].lf);
      check($sformatf("R%0d vec%0d rdata", VEC[i].req, i), rdata, VEC[i].exp);
      check($sformatf("R%0d vec%0d irq", VEC[i].req, i), {7'd0, irq}, {7'd0, VEC[i].irq});
      check($sformatf("R%0d vec%0d fiq", VEC[i].req, i), {7'd0, fiq}, {7'd0, VEC[i].fiq});
    end

    // R2: after a clear, a fresh rising edge sets the bit again
    step(1'b1, 5'd5, 8'h40, 8'h01, 8'h02, 8'h38);
    step(1'b0, 5'd4, 8'h00, 8'h00, 8'h02, 8'h38);
    step(1'b0, 5'd4, 8'h00, 8'h40, 8'h02, 8'h38);
    check("R2 re-edge sets bit 6", rdata, 8'hC1);

    // R6: fast mask drops unimplemented bits
    step(1'b1, 5'd14, 8'h38, 8'h40, 8'h02, 8'h38);
    check("R6 fast mask unimpl bits", rdata, 8'h00);

    // R3: clearing bit 7 has no effect
    step(1'b1, 5'd5, 8'h80, 8'h40, 8'h02, 8'h38);
    rd(5'd4);
    check("R3 bit7 survives clear", rdata, 8'hC1);

    // R1: reset in the middle of the run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    evt_a = 8'h00; lvl_b = 8'h00; lvl_f = 8'h00;
    @(negedge clk);
    #0.5;
    rd(5'd4);  check("R1 status A after reset", rdata, 8'h90);
    rd(5'd6);  check("R1 mask A after reset", rdata, 8'h00);
    rd(5'd10); check("R1 mask B after reset", rdata, 8'h00);
    rd(5'd14); check("R1 mask F after reset", rdata, 8'h00);
    check("R1 irq low after reset", {7'd0, irq}, 8'h00);
    rd(5'd7);  check("R11 unused offset 7", rdata, 8'h00);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule